// File: doc/BRIEF.md
# Bidirectional Overcurrent Fault Qualifier

This block sits between two digital overcurrent comparators of a battery pack protector and the control of the pack's series switch. One comparator flag reports excess current in the charge direction and the other in the discharge direction. The block watches both flags on every clock, with no dependence on any slower voltage sampling schedule. A flag trips a latched fault only after it has stayed high for a full qualification window. A shorter excursion is forgotten.

Once a fault is latched, the switch is held open and a switch-bypass enable is raised. The bypass lets the analogue side sense whether the load has gone away. A two-bit code records which direction caused the trip. The fault is released only by a rising edge on the pack enable or by a report that a very high impedance load is now present. Pulling the enable low drops the bypass at once but keeps the fault latched.

The window length `TRIP_CYC` is a parameter in clock cycles, chosen to cover roughly 6 ms at the system clock.

Top module: `ocp_latch`

## Requirements
- R1: After reset, `fault`, `bypass_en` and `fault_dir` are all 0.
- R2: When `oc_chg` is sampled high on `TRIP_CYC` consecutive clock edges while no fault is latched and `en_low` is 0, `fault` is 1 after the last of those edges and `fault_dir` is 2'b01.
- R3: The discharge flag `oc_dis` qualifies the same way and gives `fault_dir` 2'b10. If both directions complete their window on the same edge, `fault_dir` is 2'b11. `fault_dir` is 2'b00 whenever no fault is latched, and it holds its value while the fault stays latched.
- R4: A flag that goes low for even one sampled edge restarts its window from zero. An excursion shorter than `TRIP_CYC` edges never trips.
- R5: The two directions are counted separately. High samples of one flag never count toward the other flag's window.
- R6: A latched fault stays latched when both flags return low, for as long as no recovery event occurs.
- R7: `bypass_en` becomes 1 on the same edge that latches the fault. It goes to 0 on the first edge where `en_low` is 1, while `fault` stays 1.
- R8: An `en_rise` pulse while a fault is latched clears `fault`, `bypass_en` and `fault_dir` on that edge.
- R9: `hiz_load` high while a fault is latched clears the fault on that edge. When no fault is latched, `hiz_load` has no effect on the outputs or on window progress.
- R10: After a recovery, a full new window of `TRIP_CYC` consecutive high samples is needed to trip again, even if the flag stayed high throughout.
- R11: While `en_low` is 1, neither window advances and no fault can be latched. Counting starts from zero once `en_low` returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| oc_chg | input | 1 | Charge-direction overcurrent comparator flag |
| oc_dis | input | 1 | Discharge-direction overcurrent comparator flag |
| hiz_load | input | 1 | Very high impedance load detected at the pack terminals |
| en_rise | input | 1 | Single-cycle pulse on a rising pack enable |
| en_low | input | 1 | Pack enable is low (sleep) |
| fault | output | 1 | Overcurrent fault latched; the switch must be open |
| bypass_en | output | 1 | Switch-bypass resistor enable |
| fault_dir | output | 2 | Tripping direction: bit 0 charge, bit 1 discharge |

## Verification
On every cycle, the assertions check the following:
- the bypass is never active without a fault;
- a latched fault always carries a nonzero direction code;
- the latch holds, with a stable code, until a recovery event;
- an enable edge or a high impedance report clears it;
- a low enable drops the bypass and blocks any new trip;
- a new trip always follows a flag that was high.

Only the bench's scenarios can show the exact length of the qualification window and the restart after an interruption. The same holds for the independence of the two directions, the both-directions code, and the need for a fresh full window after recovery.

// File: rtl/ocp_latch.sv
module ocp_latch #(
  parameter int unsigned TRIP_CYC = 1500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       oc_chg,
  input  logic       oc_dis,
  input  logic       hiz_load,
  input  logic       en_rise,
  input  logic       en_low,
  output logic       fault,
  output logic       bypass_en,
  output logic [1:0] fault_dir
);

  localparam int unsigned CW = $clog2(TRIP_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TRIP_CYC - 1);

  logic [CW-1:0] cnt_c, cnt_d;

  wire run_ok = !fault && !en_low;
  wire trip_c = run_ok && oc_chg && (cnt_c == LAST);
  wire trip_d = run_ok && oc_dis && (cnt_d == LAST);
  wire clr    = fault && (en_rise || hiz_load);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_c     <= '0;
      cnt_d     <= '0;
      fault     <= 1'b0;
      bypass_en <= 1'b0;
      fault_dir <= 2'b00;
    end else begin
      cnt_c <= (run_ok && oc_chg) ? cnt_c + 1'b1 : '0;
      cnt_d <= (run_ok && oc_dis) ? cnt_d + 1'b1 : '0;
      if (clr) begin
        fault     <= 1'b0;
        bypass_en <= 1'b0;
        fault_dir <= 2'b00;
      end else if (trip_c || trip_d) begin
        fault     <= 1'b1;
        bypass_en <= 1'b1;
        fault_dir <= {trip_d, trip_c};
      end else if (en_low) begin
        bypass_en <= 1'b0;
      end
    end
  end

  p_bypass_needs_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_en |-> fault);

  p_dir_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fault == (fault_dir != 2'b00));

  p_trip_needs_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(oc_chg || oc_dis));

  p_latch_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !en_rise && !hiz_load) |=> (fault && $stable(fault_dir)));

  p_enable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && en_rise) |=> (!fault && !bypass_en && fault_dir == 2'b00));

  p_hiz_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && hiz_load) |=> !fault);

  p_sleep_drops_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_low |=> !bypass_en);

  p_sleep_no_trip_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_low && !fault) |=> !fault);

endmodule

// File: tb/ocp_latch_tb.sv
module ocp_latch_tb;
  localparam int TRIP = 8;

  logic clk = 0, rst_n = 0;
  logic oc_chg = 0, oc_dis = 0, hiz_load = 0, en_rise = 0, en_low = 0;
  logic fault, bypass_en;
  logic [1:0] fault_dir;

  int n_run = 0, n_fail = 0, cycles = 0;
  string cur_req = "R1";

  int m_rc = 0, m_rd = 0;
  logic m_fault = 0, m_byp = 0;
  logic [1:0] m_dir = 0;

  always #2 clk = ~clk;

  ocp_latch #(.TRIP_CYC(TRIP)) u_dut (
    .clk(clk), .rst_n(rst_n), .oc_chg(oc_chg), .oc_dis(oc_dis),
    .hiz_load(hiz_load), .en_rise(en_rise), .en_low(en_low),
    .fault(fault), .bypass_en(bypass_en), .fault_dir(fault_dir));

  always @(posedge clk) begin
    bit clr, tc, td, old_f;
    if (!rst_n) begin
      m_rc = 0; m_rd = 0; m_fault = 0; m_byp = 0; m_dir = 0;
    end else begin
      old_f = m_fault;
      clr = old_f && (en_rise || hiz_load);
      tc = !old_f && !en_low && oc_chg && (m_rc == TRIP - 1);
      td = !old_f && !en_low && oc_dis && (m_rd == TRIP - 1);
      if (clr) begin m_fault = 0; m_byp = 0; m_dir = 0; end
      else if (tc || td) begin m_fault = 1; m_byp = 1; m_dir = {td, tc}; end
      else if (en_low) m_byp = 0;
      m_rc = (!old_f && !en_low && oc_chg) ? m_rc + 1 : 0;
      m_rd = (!old_f && !en_low && oc_dis) ? m_rd + 1 : 0;
    end
  end

  task automatic check(string req, int got, int exp, string what);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check(cur_req, fault, m_fault, "model fault");
    check(cur_req, bypass_en, m_byp, "model bypass");
    check(cur_req, fault_dir, m_dir, "model dir");
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic cyc(bit c, bit d, bit h, bit r, bit l);
    oc_chg = c; oc_dis = d; hiz_load = h; en_rise = r; en_low = l;
    @(negedge clk);
  endtask

  task automatic hold(bit c, bit d, int n);
    for (int i = 0; i < n; i++) cyc(c, d, 0, 0, 0);
  endtask

  task automatic expect3(string req, int f, int b, int d);
    check(req, fault, f, "fault");
    check(req, bypass_en, b, "bypass");
    check(req, fault_dir, d, "dir");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect3("R1", 0, 0, 0);
    rst_n = 1;
    @(negedge clk);
    expect3("R1", 0, 0, 0);

    cur_req = "R2";
    hold(1, 0, TRIP - 1);
    check("R2", fault, 0, "one short of window");
    hold(1, 0, 1);
    expect3("R2", 1, 1, 1);
    cur_req = "R6";
    hold(0, 0, 10);
    expect3("R6", 1, 1, 1);
    cur_req = "R8";
    cyc(0, 0, 0, 1, 0);
    expect3("R8", 0, 0, 0);

    cur_req = "R4";
    hold(1, 0, TRIP - 1);
    hold(0, 0, 1);
    hold(1, 0, TRIP - 1);
    check("R4", fault, 0, "interrupted window");
    hold(1, 0, 1);
    expect3("R4", 1, 1, 1);
    cur_req = "R9";
    cyc(0, 0, 1, 0, 0);
    expect3("R9", 0, 0, 0);
    hold(1, 0, 4);
    cyc(1, 0, 1, 0, 0);
    hold(1, 0, TRIP - 6);
    check("R9", fault, 0, "hiz idle no effect");
    hold(1, 0, 1);
    check("R9", fault, 1, "hiz idle window intact");
    cyc(0, 0, 0, 1, 0);

    cur_req = "R3";
    hold(0, 1, TRIP);
    expect3("R3", 1, 1, 2);
    hold(1, 1, 5);
    check("R3", fault_dir, 2, "dir holds");
    cyc(0, 0, 0, 1, 0);
    hold(1, 1, TRIP);
    expect3("R3", 1, 1, 3);
    cyc(0, 0, 0, 1, 0);

    cur_req = "R5";
    for (int i = 0; i < 10; i++) begin hold(1, 0, TRIP / 2); hold(0, 1, TRIP / 2); end
    check("R5", fault, 0, "alternating flags");

    cur_req = "R7";
    hold(0, 0, 1);
    hold(0, 1, TRIP);
    check("R7", bypass_en, 1, "bypass on trip");
    cyc(0, 0, 0, 0, 1);
    expect3("R7", 1, 0, 2);
    for (int i = 0; i < 6; i++) cyc(1, 1, 0, 0, 1);
    expect3("R7", 1, 0, 2);
    cyc(0, 0, 0, 1, 0);
    expect3("R8", 0, 0, 0);

    cur_req = "R11";
    for (int i = 0; i < 3 * TRIP; i++) cyc(1, 0, 0, 0, 1);
    check("R11", fault, 0, "sleep blocks trip");
    hold(1, 0, TRIP - 1);
    check("R11", fault, 0, "window restarts after sleep");
    hold(1, 0, 1);
    check("R11", fault, 1, "trip after sleep");

    cur_req = "R10";
    cyc(1, 0, 0, 1, 0);
    check("R10", fault, 0, "cleared");
    hold(1, 0, TRIP - 1);
    check("R10", fault, 0, "fresh window needed");
    hold(1, 0, 1);
    expect3("R10", 1, 1, 1);
    cyc(0, 0, 1, 0, 0);
    hold(0, 0, 2);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule